// File: doc/BRIEF.md
# Independent Hardware Watchdog with Reset Sequencing

This block is a fixed-timeout supervisor that runs from the 32.768 kHz real-time-clock time base. It runs alongside any watchdog inside the processor and does not depend on it. Firmware keeps it quiet by writing a one to its refresh bit often enough. If the refresh stops, the counter runs out and the block raises a chip reset. That reset has the same effect as the external reset pin. The block holds the processor in reset for a fixed number of oscillator cycles and then releases it, so that it fetches from program address zero.

A sticky overflow flag lets boot code tell a watchdog restart apart from a power-up. Firmware clears the flag by writing to it, and the external reset pin also clears it. No register setting can stop the watchdog. Only the hardware disable strap or the debug-enable input stops it. The wake signal, while low, holds the counter at its start value.

Top module: `hwd_top`

## Requirements
- R1: With the watchdog enabled, `wake` high and no restart, `chip_rst` rises exactly TIMEOUT clock cycles after the last restart. The default TIMEOUT is 49152, which is 1.5 s at 32768 Hz. It never rises earlier.
- R2: A cycle with `refresh_wr`=1 and `refresh_bit`=1 restarts the full timeout period. A write with `refresh_bit`=0 leaves the pending overflow time unchanged.
- R3: A refresh in the same cycle in which the counter would overflow prevents the reset.
- R4: While `wake` is 0 the counter is held at its start value and no reset is issued. When `wake` returns high, a full timeout period follows.
- R5: While `dis_strap`=1 or `dbg_en`=1 the counter is held at its start value and no reset is issued. When the block is enabled again, a full timeout period follows.
- R6: On overflow, `chip_rst` is 1 and `cpu_run` is 0 for exactly HOLD cycles (default 4100). Then `cpu_run` returns to 1, and a full timeout period starts at the release.
- R7: `ovf_flag` is set on overflow and stays set until `flag_clr`=1 or `ext_rst`=1. If an overflow and `flag_clr` fall in the same cycle, the flag is set.
- R8: A cycle with `ext_rst`=1 clears `ovf_flag` and restarts the timeout period.
- R9: After `rst_n` (power-up), `chip_rst`=0, `cpu_run`=1 and `ovf_flag`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz oscillator clock |
| rst_n | input | 1 | Power-up reset, asynchronous assert, active low |
| refresh_wr | input | 1 | Write strobe to the refresh bit |
| refresh_bit | input | 1 | Data written to the refresh bit; a one restarts the counter |
| wake | input | 1 | Internal wake; low holds the counter at start |
| dbg_en | input | 1 | Debug enable; high stops the watchdog |
| dis_strap | input | 1 | Hardware disable strap; high stops the watchdog |
| ext_rst | input | 1 | External reset pin, active high, synchronous |
| flag_clr | input | 1 | Firmware clear of the overflow flag |
| chip_rst | output | 1 | Chip reset request during the hold window |
| cpu_run | output | 1 | Processor released to fetch from address zero |
| ovf_flag | output | 1 | Sticky overflow status |

## Verification
Most faults in the counter show up only as a shift in the cycle where `chip_rst` rises. A counter that ignores a restart, or skips or repeats a count, moves that edge by at least one cycle within one timeout period. A hold counter with a wrong length shows as a release edge of `cpu_run` that comes early or late within HOLD cycles of the overflow. A wrong flag shows at once on `ovf_flag`, either at the overflow edge or on the cycle after a clear. A reference model is therefore compared on every cycle, and directed checks are placed exactly on the predicted rise and release edges.

// File: rtl/hwd_pkg.sv
package hwd_pkg;
  localparam int unsigned HWD_TIMEOUT_DEF = 49152;
  localparam int unsigned HWD_HOLD_DEF    = 4100;

  typedef enum logic {
    HS_RUN  = 1'b0,
    HS_HOLD = 1'b1
  } hold_state_e;
endpackage

// File: rtl/hwd_timeout.sv
module hwd_timeout #(
  parameter int unsigned TIMEOUT = hwd_pkg::HWD_TIMEOUT_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic expire
);
  localparam int unsigned CW = $clog2(TIMEOUT);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    expire = !restart && (cnt_q == LAST);
    cnt_en = 1'b1;
    if (restart || expire) cnt_d = '0;
    else                   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R1
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> ($past(cnt_q) == cnt_q - 1'b1)); // R1
endmodule

// File: rtl/hwd_hold.sv
module hwd_hold #(
  parameter int unsigned HOLD = hwd_pkg::HWD_HOLD_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic active
);
  import hwd_pkg::*;
  localparam int unsigned HW = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [HW-1:0] HLAST = HW'(HOLD - 1);

  hold_state_e   st_q, st_d;
  logic [HW-1:0] hc_q, hc_d;

  always_comb begin
    st_d = st_q;
    hc_d = hc_q;
    case (st_q)
      HS_RUN: begin
        if (fire) begin
          st_d = HS_HOLD;
          hc_d = '0;
        end
      end
      HS_HOLD: begin
        if (hc_q == HLAST) begin
          st_d = HS_RUN;
          hc_d = '0;
        end else begin
          hc_d = hc_q + 1'b1;
        end
      end
      default: st_d = HS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= HS_RUN;
      hc_q <= '0;
    end else begin
      st_q <= st_d;
      hc_q <= hc_d;
    end
  end

  assign active = (st_q == HS_HOLD);

  AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    hc_q <= HLAST); // R6
  AST_HOLD_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (active && hc_q != HLAST) |=> active); // R6
  AST_HOLD_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (active && hc_q == HLAST) |=> !active); // R6
endmodule

// File: rtl/hwd_flag.sv
module hwd_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_q, flag_d, flag_en;

  always_comb begin
    flag_en = set || clr;
    flag_d  = set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag = flag_q;

  AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag); // R7
endmodule

// File: rtl/hwd_top.sv
module hwd_top #(
  parameter int unsigned TIMEOUT = hwd_pkg::HWD_TIMEOUT_DEF,
  parameter int unsigned HOLD    = hwd_pkg::HWD_HOLD_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic refresh_wr,
  input  logic refresh_bit,
  input  logic wake,
  input  logic dbg_en,
  input  logic dis_strap,
  input  logic ext_rst,
  input  logic flag_clr,
  output logic chip_rst,
  output logic cpu_run,
  output logic ovf_flag
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       enabled, refresh_hit, restart, expire, hold_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    enabled     = !dis_strap && !dbg_en;
    refresh_hit = refresh_wr && refresh_bit;
    restart     = refresh_hit || ext_rst || !wake || !enabled || hold_active;
  end

  hwd_timeout #(.TIMEOUT(TIMEOUT)) u_cnt (
    .clk(clk), .rst_n(rst_int_n), .restart(restart), .expire(expire)
  );

  hwd_hold #(.HOLD(HOLD)) u_hold (
    .clk(clk), .rst_n(rst_int_n), .fire(expire), .active(hold_active)
  );

  hwd_flag u_flag (
    .clk(clk), .rst_n(rst_int_n), .set(expire),
    .clr(flag_clr || ext_rst), .flag(ovf_flag)
  );

  assign chip_rst = hold_active;
  assign cpu_run  = !hold_active;

  AST_REFRESH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (refresh_hit && !chip_rst) |=> !chip_rst); // R3
  AST_WAKE_LOW_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!wake && !chip_rst) |=> !chip_rst); // R4
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!enabled && !chip_rst) |=> !chip_rst); // R5
  AST_EXT_CLEARS: assert property (@(posedge clk) disable iff (!rst_int_n)
    ext_rst |=> !ovf_flag); // R8
  AST_FLAG_ON_RESET: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(chip_rst) |-> ovf_flag); // R7
endmodule

// File: tb/hwd_top_test.sv
module hwd_top_test;
  localparam int T = 40;
  localparam int H = 12;

  logic clk = 1'b0;
  logic rst_n, refresh_wr, refresh_bit, wake, dbg_en, dis_strap, ext_rst, flag_clr;
  logic chip_rst, cpu_run, ovf_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit cmp_en = 0;

  // reference model state
  int m_sync, m_cnt, m_hc;
  bit m_hold, m_flag;

  always #10 clk = ~clk;

  hwd_top #(.TIMEOUT(T), .HOLD(H)) uut (
    .clk(clk), .rst_n(rst_n), .refresh_wr(refresh_wr), .refresh_bit(refresh_bit),
    .wake(wake), .dbg_en(dbg_en), .dis_strap(dis_strap), .ext_rst(ext_rst),
    .flag_clr(flag_clr), .chip_rst(chip_rst), .cpu_run(cpu_run), .ovf_flag(ovf_flag)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync <= 0; m_cnt <= 0; m_hc <= 0; m_hold <= 0; m_flag <= 0;
    end else begin
      bit ovf;
      ovf = 0;
      if (m_sync < 2) begin
        m_cnt <= 0; m_hc <= 0; m_hold <= 0; m_flag <= 0;
      end else begin
        if (m_hold) begin
          m_cnt <= 0;
          if (m_hc == H - 1) begin m_hold <= 0; m_hc <= 0; end
          else m_hc <= m_hc + 1;
        end else if (dis_strap || dbg_en || !wake || (refresh_wr && refresh_bit) || ext_rst) begin
          m_cnt <= 0;
        end else if (m_cnt == T - 1) begin
          ovf = 1; m_cnt <= 0; m_hold <= 1; m_hc <= 0;
        end else begin
          m_cnt <= m_cnt + 1;
        end
        if (ovf) m_flag <= 1;
        else if (ext_rst || flag_clr) m_flag <= 0;
      end
      if (m_sync < 2) m_sync <= m_sync + 1;
    end
  end

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      chk("R6 model chip_rst", chip_rst, m_hold);
      chk("R6 model cpu_run", cpu_run, !m_hold);
      chk("R7 model ovf_flag", ovf_flag, m_flag);
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic refresh(bit b);
    refresh_wr = 1; refresh_bit = b;
    tick(1);
    refresh_wr = 0; refresh_bit = 0;
  endtask

  task automatic wait_release();
    tick(H);
    chk("R6 release", cpu_run, 1'b1);
  endtask

  initial begin
    rst_n = 0; refresh_wr = 0; refresh_bit = 0; wake = 1; dbg_en = 0;
    dis_strap = 0; ext_rst = 0; flag_clr = 0;
    tick(3);
    rst_n = 1;
    tick(3);
    cmp_en = 1;
    chk("R9 chip_rst", chip_rst, 1'b0);
    chk("R9 cpu_run", cpu_run, 1'b1);
    chk("R9 ovf_flag", ovf_flag, 1'b0);

    // R1 / R6 / R7: plain overflow
    refresh(1);
    tick(T - 1);
    chk("R1 not early", chip_rst, 1'b0);
    tick(1);
    chk("R1 overflow", chip_rst, 1'b1);
    chk("R7 flag set", ovf_flag, 1'b1);
    chk("R6 cpu held", cpu_run, 1'b0);
    tick(H - 1);
    chk("R6 still held", chip_rst, 1'b1);
    tick(1);
    chk("R6 released", cpu_run, 1'b1);
    chk("R7 flag sticky", ovf_flag, 1'b1);
    flag_clr = 1; tick(1); flag_clr = 0;
    chk("R7 flag cleared", ovf_flag, 1'b0);

    // R2: a zero write is ignored
    refresh(1);
    tick(10);
    refresh(0);
    tick(T - 12);
    chk("R2 zero write no early", chip_rst, 1'b0);
    tick(1);
    chk("R2 zero write ignored", chip_rst, 1'b1);
    wait_release();

    // R3: refresh on the overflow cycle
    refresh(1);
    tick(T - 1);
    refresh(1);
    chk("R3 refresh wins", chip_rst, 1'b0);
    tick(T - 1);
    chk("R2 full period after refresh", chip_rst, 1'b0);
    tick(1);
    chk("R2 overflow after refresh", chip_rst, 1'b1);
    wait_release();

    // R4: wake low holds
    refresh(1);
    tick(30);
    wake = 0;
    tick(100);
    chk("R4 wake low quiet", chip_rst, 1'b0);
    wake = 1;
    tick(T - 1);
    chk("R4 full period", chip_rst, 1'b0);
    tick(1);
    chk("R4 overflow after wake", chip_rst, 1'b1);
    wait_release();

    // R5: strap and debug enable
    refresh(1);
    tick(30);
    dis_strap = 1;
    tick(100);
    chk("R5 strap quiet", chip_rst, 1'b0);
    dis_strap = 0;
    tick(T - 1);
    chk("R5 full period after strap", chip_rst, 1'b0);
    dbg_en = 1;
    tick(100);
    chk("R5 debug quiet", chip_rst, 1'b0);
    dbg_en = 0;
    tick(T - 1);
    chk("R5 no early after debug", chip_rst, 1'b0);
    tick(1);
    chk("R5 overflow after debug", chip_rst, 1'b1);
    wait_release();

    // R8: external reset clears flag and restarts
    tick(20);
    ext_rst = 1; tick(1); ext_rst = 0;
    chk("R8 flag cleared", ovf_flag, 1'b0);
    tick(T - 1);
    chk("R8 restart no early", chip_rst, 1'b0);
    tick(1);
    chk("R8 overflow after restart", chip_rst, 1'b1);
    wait_release();

    // R7: set wins over clear
    flag_clr = 1; tick(1); flag_clr = 0;
    chk("R7 cleared before", ovf_flag, 1'b0);
    refresh(1);
    tick(T - 1);
    flag_clr = 1; tick(1); flag_clr = 0;
    chk("R7 set wins", ovf_flag, 1'b1);
    wait_release();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule